// File: doc/BRIEF.md
# GPIO Port with Interrupt-on-Change

This block is an eight-pin bidirectional general-purpose I/O port. Software reaches it through a small register interface with four registers: the port register, the output latch, the direction register and a control register. The block drives an output enable, an output data bit and a weak pull-up enable to each pad. It also samples the pad inputs through a synchronizer. A direction bit of 1 makes the pin an input. A direction bit of 0 drives the latch value onto the pad. One active-low control bit turns on the pull-ups of all input pins at once.

The upper four pins can raise a change interrupt. Each input pin in that group is compared against a snapshot of its level. The snapshot is taken whenever the port register is read or written. Any difference sets a sticky flag, and the flag can also request a wake-up. Software ends the mismatch by touching the port register. It must then let one more cycle pass before a write of 0 to the flag takes effect. The lower six pins can each be handed to an external segment-drive function. While a pin is handed over, the port neither drives it, pulls it up, reads it nor watches it for changes.

Top module: `gpio_ioc_port`

## Requirements
- R1: After synchronous reset, direction reads 0xFF (all inputs), the latch reads 0x00, control reads 0x80 (pull-ups disabled, wake off, flag clear), and padOe and padPullUp are 0.
- R2: The register map is: address 0 is the port register, 1 the latch, 2 direction and 3 control. padOe[i] is the inverse of direction bit i, and padOut[i] is latch bit i. As an example, direction 0xCF gives padOe 0x30.
- R3: Control bit 7 is an active-low pull-up enable. When it is 0, padPullUp[i] is 1 exactly for the pins whose direction bit is 1. A pin configured as an output never has its pull-up on.
- R4: A read of address 0 returns the pad levels two clocks after they were applied. A read of address 1 returns the latch. A write to either address 0 or address 1 loads the latch.
- R5: When an input pin among bits 7:4 differs from its snapshot, control bit 0 (the change flag) is set. Pins 3:0 never set it.
- R6: A pin among bits 7:4 whose direction bit is 0 is excluded from the comparison.
- R7: While a mismatch exists, the flag is set again every cycle, so writing 0 to the flag has no effect.
- R8: Any read or write of address 0 copies the synchronized levels of bits 7:4 into the snapshot. A write to address 1 does not.
- R9: A write of 0 to the flag is ignored in the cycle right after the mismatch ends, and it takes effect one cycle later. Writing 1 to the flag never changes it.
- R10: segEnable[i] (for bits 5:0) forces padOe[i], padOut[i] and padPullUp[i] to 0. It also makes port-read bit i return 0 and removes pin i from change detection.
- R11: changeIrq mirrors the flag. wakeReq is the flag ANDed with control bit 1 (wake enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (an access to address 0 refreshes the snapshot) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| padIn | input | 8 | Asynchronous pad levels |
| segEnable | input | 6 | Per-pin handover to segment drive, bits 5:0 |
| padOut | output | 8 | Pad output data |
| padOe | output | 8 | Pad output enable |
| padPullUp | output | 8 | Weak pull-up enable |
| changeIrq | output | 1 | Change interrupt flag |
| wakeReq | output | 1 | Wake request from the change flag |

## Verification
The direction sweep covers all 256 direction values with the latch set to the complement of the direction. This separates the output-enable polarity from the data path, and it also shows the pull-ups following the inputs. A walking single-pin pattern tells the monitored upper nibble apart from the unmonitored lower nibble. Separate sequences then cover an output pin, a handed-over pin, a latch-only write and a clear attempted one cycle too early. Each of these shows a mismatch that must or must not set the flag, or must not be cleared. A 64-value segment sweep, once with all inputs and once with all outputs, shows the masking on every enable, read and pull-up path.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PORT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LATCH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd3;

  typedef struct packed {
    logic portAccess;
    logic latchWr;
    logic dirWr;
    logic ctrlWr;
  } regStrobe_t;
endpackage

// File: rtl/gpio_ioc_ctrl.sv
module gpio_ioc_ctrl
  import gpio_ioc_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [PORT_W-1:0]     regWrData,
  input  logic                  mismatch,
  output regStrobe_t            strobe,
  output logic [PORT_W-1:0]     ctrlValue,
  output logic                  changeFlag,
  output logic                  wakeEnable
);
  localparam int FLAG_BIT = 0;
  localparam int WAKE_BIT = 1;
  localparam int PULL_BIT = PORT_W - 1;

  logic pullDisable;
  logic mismatchQ;
  logic clearOk;
  logic clearReq;

  always_comb begin
    strobe.portAccess = (regWrEn || regRdEn) && (regAddr == ADDR_PORT);
    strobe.latchWr    = regWrEn && ((regAddr == ADDR_PORT) || (regAddr == ADDR_LATCH));
    strobe.dirWr      = regWrEn && (regAddr == ADDR_DIR);
    strobe.ctrlWr     = regWrEn && (regAddr == ADDR_CTRL);
  end

  // a clear sticks only once the mismatch has been gone for a full cycle
  assign clearOk  = !mismatch && !mismatchQ;
  assign clearReq = strobe.ctrlWr && !regWrData[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mismatchQ   <= 1'b0;
      changeFlag  <= 1'b0;
      pullDisable <= 1'b1;
      wakeEnable  <= 1'b0;
    end else begin
      mismatchQ <= mismatch;
      if (mismatch) begin
        changeFlag <= 1'b1;
      end else if (clearReq && clearOk) begin
        changeFlag <= 1'b0;
      end
      if (strobe.ctrlWr) begin
        pullDisable <= regWrData[PULL_BIT];
        wakeEnable  <= regWrData[WAKE_BIT];
      end
    end
  end

  always_comb begin
    ctrlValue           = '0;
    ctrlValue[FLAG_BIT] = changeFlag;
    ctrlValue[WAKE_BIT] = wakeEnable;
    ctrlValue[PULL_BIT] = pullDisable;
  end
endmodule

// File: rtl/gpio_ioc_datapath.sv
module gpio_ioc_datapath
  import gpio_ioc_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int IOC_LSB     = 4,
  parameter int SEG_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  regStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [PORT_W-1:0]     regWrData,
  input  logic [PORT_W-1:0]     ctrlValue,
  input  logic [PORT_W-1:0]     padIn,
  input  logic [SEG_W-1:0]      segEnable,
  output logic [PORT_W-1:0]     regRdData,
  output logic [PORT_W-1:0]     padOut,
  output logic [PORT_W-1:0]     padOe,
  output logic [PORT_W-1:0]     padPullUp,
  output logic                  mismatch
);
  localparam int IOC_W    = PORT_W - IOC_LSB;
  localparam int PULL_BIT = PORT_W - 1;

  logic [PORT_W-1:0] latchReg;
  logic [PORT_W-1:0] dirReg;
  logic [IOC_W-1:0]  snapshot;
  logic [PORT_W-1:0] syncStage [SYNC_STAGES];
  logic [PORT_W-1:0] pinSync;
  logic [PORT_W-1:0] segMask;
  logic [IOC_W-1:0]  watchMask;

  generate
    if (SEG_W < PORT_W) begin : g_segPad
      assign segMask = {{(PORT_W-SEG_W){1'b0}}, segEnable};
    end else begin : g_segFull
      assign segMask = segEnable[PORT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncStage[k] <= '0;
    end else begin
      syncStage[0] <= padIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncStage[k] <= syncStage[k-1];
    end
  end
  assign pinSync = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      latchReg <= '0;
      dirReg   <= '1;
      snapshot <= '0;
    end else begin
      if (strobe.latchWr)    latchReg <= regWrData;
      if (strobe.dirWr)      dirReg   <= regWrData;
      if (strobe.portAccess) snapshot <= pinSync[PORT_W-1:IOC_LSB];
    end
  end

  assign watchMask = dirReg[PORT_W-1:IOC_LSB] & ~segMask[PORT_W-1:IOC_LSB];
  assign mismatch  = |((pinSync[PORT_W-1:IOC_LSB] ^ snapshot) & watchMask);

  assign padOe     = ~dirReg & ~segMask;
  assign padOut    = latchReg & ~segMask;
  assign padPullUp = {PORT_W{~ctrlValue[PULL_BIT]}} & dirReg & ~segMask;

  always_comb begin
    case (regAddr)
      ADDR_PORT:  regRdData = pinSync & ~segMask;
      ADDR_LATCH: regRdData = latchReg;
      ADDR_DIR:   regRdData = dirReg;
      default:    regRdData = ctrlValue;
    endcase
  end
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
  import gpio_ioc_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int IOC_LSB     = 4,
  parameter int SEG_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [PORT_W-1:0] regWrData,
  output logic [PORT_W-1:0] regRdData,
  input  logic [PORT_W-1:0] padIn,
  input  logic [SEG_W-1:0]  segEnable,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padPullUp,
  output logic              changeIrq,
  output logic              wakeReq
);
  regStrobe_t        strobe;
  logic [PORT_W-1:0] ctrlValue;
  logic              mismatch;
  logic              changeFlag;
  logic              wakeEnable;

  gpio_ioc_ctrl #(.PORT_W(PORT_W)) u_ctrl (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .mismatch(mismatch), .strobe(strobe),
    .ctrlValue(ctrlValue), .changeFlag(changeFlag), .wakeEnable(wakeEnable)
  );

  gpio_ioc_datapath #(
    .PORT_W(PORT_W), .IOC_LSB(IOC_LSB), .SEG_W(SEG_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .regAddr(regAddr), .regWrData(regWrData),
    .ctrlValue(ctrlValue), .padIn(padIn), .segEnable(segEnable), .regRdData(regRdData),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp), .mismatch(mismatch)
  );

  assign changeIrq = changeFlag;
  assign wakeReq   = changeFlag & wakeEnable;
endmodule

// File: rtl/gpio_ioc_port_chk.sv
module gpio_ioc_port_chk #(
  parameter int PORT_W = 8,
  parameter int SEG_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [PORT_W-1:0] padOe,
  input logic [PORT_W-1:0] padPullUp,
  input logic [SEG_W-1:0]  segEnable,
  input logic              changeIrq,
  input logic              wakeReq,
  input logic              mismatch
);
  logic rstQ = 1'b0;
  always_ff @(posedge clk) rstQ <= rst;

  // R1: outputs are quiet in the cycle after a reset edge
  always @(posedge clk) begin
    if (rstQ === 1'b1) begin
      assert_reset_quiet_R1: assert (padOe == '0 && padPullUp == '0);
    end
  end

  // R3: never pull up a driven pin
  assert_pull_not_driven_R3: assert property (@(posedge clk) disable iff (rst)
    (padPullUp & padOe) == '0);

  // R10: handed-over pins neither driven nor pulled up
  assert_seg_released_R10: assert property (@(posedge clk) disable iff (rst)
    ((padOe[SEG_W-1:0] | padPullUp[SEG_W-1:0]) & segEnable) == '0);

  // R7: a mismatch always leaves the flag set next cycle
  assert_mismatch_sets_R7: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> changeIrq);

  // R9: flag only falls after two quiet cycles
  assert_clear_delay_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(changeIrq) |-> (!$past(mismatch, 1) && !$past(mismatch, 2)));

  // R11: wake only with the flag
  assert_wake_needs_flag_R11: assert property (@(posedge clk) disable iff (rst)
    wakeReq |-> changeIrq);
endmodule

bind gpio_ioc_port gpio_ioc_port_chk #(.PORT_W(PORT_W), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst(rst), .padOe(padOe), .padPullUp(padPullUp), .segEnable(segEnable),
  .changeIrq(changeIrq), .wakeReq(wakeReq), .mismatch(mismatch)
);

// File: tb/gpio_ioc_port_tb.sv
module gpio_ioc_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] padIn = '0;
  logic [5:0] segEnable = '0;
  logic [7:0] padOut, padOe, padPullUp;
  logic       changeIrq, wakeReq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rd;

  gpio_ioc_port u_dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .padIn(padIn), .segEnable(segEnable),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp),
    .changeIrq(changeIrq), .wakeReq(wakeReq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    check("R1 padPullUp", padPullUp, 8'h00);
    regRead(2'd2, rd); check("R1 dir", rd, 8'hFF);
    regRead(2'd1, rd); check("R1 latch", rd, 8'h00);
    regRead(2'd3, rd); check("R1 ctrl", rd, 8'h80);

    // R2/R3 direction sweep with pull-ups enabled
    regWrite(2'd3, 8'h00);
    for (int d = 0; d < 256; d++) begin
      regWrite(2'd2, d[7:0]);
      regWrite(2'd1, ~d[7:0]);
      check("R2 padOe", padOe, ~d[7:0]);
      check("R2 padOut", padOut, ~d[7:0]);
      check("R3 pullup", padPullUp, d[7:0]);
    end
    regWrite(2'd2, 8'hCF);
    check("R2 dir 0xCF", padOe, 8'h30);
    regWrite(2'd3, 8'h80);
    check("R3 pull off", padPullUp, 8'h00);

    // R4 port read sweep and latch access
    regWrite(2'd2, 8'hFF);
    for (int v = 0; v < 256; v++) begin
      padIn = v[7:0];
      tick(2);
      regRead(2'd0, rd);
      check("R4 port read", rd, v[7:0]);
    end
    padIn = 8'h00; tick(2);
    regRead(2'd0, rd);
    tick(1);
    regWrite(2'd3, 8'h80);
    regWrite(2'd0, 8'h5A);
    regRead(2'd1, rd); check("R4 port write to latch", rd, 8'h5A);
    regWrite(2'd1, 8'hA5);
    regRead(2'd1, rd); check("R4 latch write", rd, 8'hA5);
    regRead(2'd3, rd); check("R4 flag quiet", rd, 8'h80);

    // R5 walking pin
    for (int i = 0; i < 8; i++) begin
      padIn = 8'h01 << i;
      tick(3);
      regRead(2'd3, rd);
      check("R5 flag per pin", rd[0], (i >= 4) ? 8'h01 : 8'h00);
      padIn = 8'h00; tick(3);
      regRead(2'd0, rd); tick(1);
      regWrite(2'd3, 8'h80);
      regRead(2'd3, rd);
      check("R5 flag cleared", rd, 8'h80);
    end

    // R7 persistent mismatch blocks clear
    padIn = 8'h80; tick(3);
    regWrite(2'd3, 8'h80);
    regRead(2'd3, rd); check("R7 clear ignored", rd, 8'h81);
    // R9 early clear ignored, later clear accepted
    regRead(2'd0, rd);
    regWrite(2'd3, 8'h80);
    regRead(2'd3, rd); check("R9 early clear", rd, 8'h81);
    regWrite(2'd3, 8'h80);
    regRead(2'd3, rd); check("R9 late clear", rd, 8'h80);
    regWrite(2'd3, 8'h81);
    regRead(2'd3, rd); check("R9 write one", rd, 8'h80);

    // R6 output pin excluded
    regWrite(2'd2, 8'h7F);
    padIn = 8'h00; tick(3);
    regRead(2'd3, rd); check("R6 output excluded", rd, 8'h80);
    regWrite(2'd2, 8'hFF);
    padIn = 8'h80; tick(3);
    regRead(2'd0, rd); tick(1);
    regWrite(2'd3, 8'h80);

    // R8 latch write does not refresh, port write does
    padIn = 8'hC0; tick(3);
    regWrite(2'd1, 8'h00); tick(1);
    regWrite(2'd3, 8'h80);
    regRead(2'd3, rd); check("R8 latch no refresh", rd, 8'h81);
    regWrite(2'd0, 8'h00); tick(1);
    regWrite(2'd3, 8'h80);
    regRead(2'd3, rd); check("R8 port write refresh", rd, 8'h80);

    // R10 segment pin excluded from change detection
    segEnable = 6'h10;
    padIn = 8'hD0; tick(3);
    regRead(2'd3, rd); check("R10 seg excluded", rd, 8'h80);
    segEnable = 6'h00; tick(3);
    regRead(2'd0, rd); tick(1);
    regWrite(2'd3, 8'h80);

    // R11 wake request
    regWrite(2'd3, 8'h82);
    check("R11 no wake", {6'd0, wakeReq, changeIrq}, 8'h00);
    padIn = 8'h00; tick(3);
    check("R11 wake", {6'd0, wakeReq, changeIrq}, 8'h03);
    regRead(2'd0, rd); tick(1);
    regWrite(2'd3, 8'h80);
    padIn = 8'h10; tick(3);
    check("R11 no wake when off", {6'd0, wakeReq, changeIrq}, 8'h01);
    regRead(2'd0, rd); tick(1);
    regWrite(2'd3, 8'h80);

    // R10 segment sweep
    regWrite(2'd3, 8'h00);
    regWrite(2'd1, 8'hFF);
    padIn = 8'hFF; tick(2);
    for (int s = 0; s < 64; s++) begin
      segEnable = s[5:0];
      #1;
      check("R10 pullup mask", padPullUp, ~{2'b00, s[5:0]});
      check("R10 oe inputs", padOe, 8'h00);
      regRead(2'd0, rd);
      check("R10 port read mask", rd, ~{2'b00, s[5:0]});
    end
    regWrite(2'd2, 8'h00);
    for (int s = 0; s < 64; s++) begin
      segEnable = s[5:0];
      #1;
      check("R10 oe mask", padOe, ~{2'b00, s[5:0]});
      check("R10 out mask", padOut, ~{2'b00, s[5:0]});
      check("R10 pull outputs", padPullUp, 8'h00);
      tick(1);
    end
    segEnable = '0;
    tick(2);
    finishRun();
  end
endmodule